// File: doc/BRIEF.md
# Secondary Boot Address Remapper

This block sits in the address path of a multiprocessor cluster. It rewrites the physical addresses that secondary processors issue. A secondary that is being brought up normally fetches its first instructions from ROM at physical address 0. When remapping is switched on for that secondary, its accesses to the lowest 2 MB are steered to a 2 MB-aligned region of system memory chosen by the boot code. The master processor never sees this redirection, and neither does any secondary whose remap is off.

The target region is given by two 4-bit base registers that are written separately:
- The low register holds target address bits 24:21. Boot code writes it with the physical address shifted right by 21.
- The high register holds bits 28:25. Boot code writes it with the address shifted right by 25.

A per-secondary enable mask is changed by set and clear write strobes. Register writes take effect at the next clock edge. The translation itself is purely combinational.

Top module: `boot_remap`

## Requirements
- R1: After reset both base registers are 0 and every remap enable is clear, so every request passes through unchanged with `xlat_remapped` low.
- R2: A base-low write loads `base_wdata` as target bits 24:21. A base-high write loads it as target bits 28:25. Either write takes effect for requests from the cycle after the write's clock edge.
- R3: A set write ORs `remap_wdata` into the enable mask, and a clear write removes the bits of `remap_wdata` from it. When both strobes are active in the same cycle, the clear wins for the bits they share. Bit i of the mask belongs to secondary i.
- R4: A request is translated when all of these hold: req_id[2] is 1 (the request is from a secondary), the mask bit selected by req_id[1:0] is set, and req_addr[31:21] is zero. The translated address then has bits 31:29 at 0, bits 28:25 from the high base, bits 24:21 from the low base and bits 20:0 from req_addr, and `xlat_remapped` is 1.
- R5: A request with any of req_addr[31:21] non-zero passes through unchanged, even from an enabled secondary. This holds at the window edge: 0x001FFFFF is translated and 0x00200000 is not.
- R6: A request with req_id[2] at 0 (from the master) passes through unchanged whatever the mask holds.
- R7: A request from a secondary whose mask bit is clear passes through unchanged, whatever the base registers hold.
- R8: The output follows the request in the same cycle. A change of `req_addr` or `req_id` with no clock edge in between changes `xlat_addr` at once.
- R9: A write to one base register leaves the other one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_lo_wr | input | 1 | Load `base_wdata` into target bits 24:21 |
| base_hi_wr | input | 1 | Load `base_wdata` into target bits 28:25 |
| base_wdata | input | 4 | Nibble value for a base write |
| remap_set_wr | input | 1 | Set the enable bits given in `remap_wdata` |
| remap_clr_wr | input | 1 | Clear the enable bits given in `remap_wdata` |
| remap_wdata | input | 4 | Enable mask operand, bit i for secondary i |
| req_id | input | 3 | Requester: bit 2 marks a secondary, bits 1:0 give its index |
| req_addr | input | 32 | Physical address of the request |
| xlat_addr | output | 32 | Translated physical address |
| xlat_remapped | output | 1 | High when the request was redirected |

## Verification
Register writes (R2, R3, R9) show up one clock edge after the strobe is applied. Translation (R4 to R8) is due in the same cycle as the request. The bench drives all inputs just after a falling edge and compares both outputs a moment later, well before the next rising edge. Its reference model updates its own copies of the registers on the rising edge, so every comparison sees the state after the last edge and the request of the current cycle. For R8, the request changes twice inside one clock low phase and each value is checked with no edge between them.

// File: rtl/boot_remap_pkg.sv
// Package: shared types for the secondary boot address remapper.
// Assumes the base is two equal nibbles that together cover 8 address bits.
package boot_remap_pkg;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned BASE_W = 2 * NIB_W;

    // Programmed redirect base; hi is the upper nibble of the target.
    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } remap_base_t;

endpackage

// File: rtl/remap_base_regs.sv
// Module: remap_base_regs
// Holds the two separately written nibbles of the redirect base.
// Assumes a write strobe is a single-cycle pulse; both may be active at once.
module remap_base_regs
    import boot_remap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [NIB_W-1:0] wdata,
    output remap_base_t      base_q
);

    // Load each nibble independently; reset returns both to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            if (lo_wr) base_q.lo <= wdata;
            if (hi_wr) base_q.hi <= wdata;
        end
    end

endmodule

// File: rtl/remap_enable_mask.sv
// Module: remap_enable_mask
// Per-secondary remap enables, changed by set and clear strobes.
// Assumes that when both strobes fire together the clear takes priority.
module remap_enable_mask #(
    parameter int unsigned SEC_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [SEC_N-1:0] wdata,
    output logic [SEC_N-1:0] mask_q
);

    logic [SEC_N-1:0] set_bits;
    logic [SEC_N-1:0] clr_bits;
    logic [SEC_N-1:0] mask_d;

    // Form the next mask: OR in set bits, then strip clear bits.
    always_comb begin
        set_bits = set_wr ? wdata : '0;
        clr_bits = clr_wr ? wdata : '0;
        mask_d   = (mask_q | set_bits) & ~clr_bits;
    end

    // Register the mask; reset disables every secondary.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/remap_xlate.sv
// Module: remap_xlate
// Combinational address translation for one request per cycle.
// Assumes req_id MSB flags a secondary and the low bits index the mask.
module remap_xlate
    import boot_remap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SEC_N     = 4,
    parameter int unsigned WIN_SHIFT = 21,
    localparam int unsigned IDX_W    = (SEC_N > 1) ? $clog2(SEC_N) : 1,
    localparam int unsigned ID_W     = IDX_W + 1
) (
    input  logic [SEC_N-1:0]  mask,
    input  remap_base_t       base,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              xlat_remapped
);

    localparam int unsigned TOP = WIN_SHIFT + BASE_W;

    logic [IDX_W-1:0]  sec_idx;
    logic              from_sec;
    logic              sec_enabled;
    logic              in_window;
    logic [ADDR_W-1:0] redirected;

    // Decode requester and check its enable bit.
    always_comb begin
        sec_idx     = req_id[IDX_W-1:0];
        from_sec    = req_id[ID_W-1];
        sec_enabled = 1'b0;
        for (int i = 0; i < int'(SEC_N); i++) begin
            if (int'(sec_idx) == i) sec_enabled = mask[i];
        end
    end

    // Detect whether the address lies in the low window.
    always_comb begin
        in_window = (req_addr[ADDR_W-1:WIN_SHIFT] == '0);
    end

    // Build the redirected address; pad or trim to the address width.
    generate
        if (ADDR_W > TOP) begin : g_pad
            assign redirected = {{(ADDR_W-TOP){1'b0}}, base,
                                 req_addr[WIN_SHIFT-1:0]};
        end else begin : g_trim
            logic [TOP-1:0] full_addr;
            assign full_addr  = {base, req_addr[WIN_SHIFT-1:0]};
            assign redirected = full_addr[ADDR_W-1:0];
        end
    endgenerate

    // Select between redirected and bypass address.
    always_comb begin
        xlat_remapped = from_sec && sec_enabled && in_window;
        xlat_addr     = xlat_remapped ? redirected : req_addr;
    end

endmodule

// File: rtl/boot_remap.sv
// Module: boot_remap (top)
// Redirects low-window fetches of enabled secondaries to a programmed
// 2 MB-aligned memory page. Assumes WIN_SHIFT + 8 <= ADDR_W.
module boot_remap
    import boot_remap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SEC_N     = 4,
    parameter int unsigned WIN_SHIFT = 21,
    localparam int unsigned IDX_W    = (SEC_N > 1) ? $clog2(SEC_N) : 1,
    localparam int unsigned ID_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_lo_wr,
    input  logic              base_hi_wr,
    input  logic [NIB_W-1:0]  base_wdata,
    input  logic              remap_set_wr,
    input  logic              remap_clr_wr,
    input  logic [SEC_N-1:0]  remap_wdata,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              xlat_remapped
);

    remap_base_t      base_q;
    logic [SEC_N-1:0] mask_q;

    remap_base_regs u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_wr  (base_lo_wr),
        .hi_wr  (base_hi_wr),
        .wdata  (base_wdata),
        .base_q (base_q)
    );

    remap_enable_mask #(.SEC_N(SEC_N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (remap_set_wr),
        .clr_wr (remap_clr_wr),
        .wdata  (remap_wdata),
        .mask_q (mask_q)
    );

    remap_xlate #(
        .ADDR_W    (ADDR_W),
        .SEC_N     (SEC_N),
        .WIN_SHIFT (WIN_SHIFT)
    ) u_xlate (
        .mask          (mask_q),
        .base          (base_q),
        .req_id        (req_id),
        .req_addr      (req_addr),
        .xlat_addr     (xlat_addr),
        .xlat_remapped (xlat_remapped)
    );

endmodule

// File: rtl/boot_remap_chk.sv
// Module: boot_remap_chk
// Assertion checker attached to every boot_remap instance.
module boot_remap_chk
    import boot_remap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SEC_N     = 4,
    parameter int unsigned WIN_SHIFT = 21,
    localparam int unsigned IDX_W    = (SEC_N > 1) ? $clog2(SEC_N) : 1,
    localparam int unsigned ID_W     = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_lo_wr,
    input logic              base_hi_wr,
    input logic [NIB_W-1:0]  base_wdata,
    input logic              remap_clr_wr,
    input logic [SEC_N-1:0]  remap_wdata,
    input logic [ID_W-1:0]   req_id,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] xlat_addr,
    input logic              xlat_remapped,
    input remap_base_t       base_q,
    input logic [SEC_N-1:0]  mask_q
);

    // R5: addresses outside the low window are never altered
    a_r5_outside_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[ADDR_W-1:WIN_SHIFT] != '0) |-> (xlat_addr == req_addr && !xlat_remapped));

    // R6: master requests are never altered
    a_r6_master_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !req_id[ID_W-1] |-> (xlat_addr == req_addr && !xlat_remapped));

    // R7: a secondary with its enable clear is never altered
    a_r7_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_id[ID_W-1] && !mask_q[req_id[IDX_W-1:0]]) |-> (xlat_addr == req_addr));

    // R4: a redirected address keeps its window offset and carries the base
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_remapped |-> (xlat_addr[WIN_SHIFT-1:0] == req_addr[WIN_SHIFT-1:0]
                           && xlat_addr[WIN_SHIFT+BASE_W-1:WIN_SHIFT] == base_q));

    // R2: a low write lands in the low nibble one edge later
    a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        base_lo_wr |=> (base_q.lo == $past(base_wdata)));

    // R9: a high-only write leaves the low nibble alone
    a_r9_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (base_hi_wr && !base_lo_wr) |=> $stable(base_q.lo));

    // R3: cleared bits are off after the edge, even with a set alongside
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        remap_clr_wr |=> ((mask_q & $past(remap_wdata)) == '0));

endmodule

bind boot_remap boot_remap_chk #(
    .ADDR_W    (ADDR_W),
    .SEC_N     (SEC_N),
    .WIN_SHIFT (WIN_SHIFT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_lo_wr    (base_lo_wr),
    .base_hi_wr    (base_hi_wr),
    .base_wdata    (base_wdata),
    .remap_clr_wr  (remap_clr_wr),
    .remap_wdata   (remap_wdata),
    .req_id        (req_id),
    .req_addr      (req_addr),
    .xlat_addr     (xlat_addr),
    .xlat_remapped (xlat_remapped),
    .base_q        (base_q),
    .mask_q        (mask_q)
);

// File: tb/boot_remap_tb.sv
module boot_remap_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_lo_wr, base_hi_wr;
    logic [3:0]  base_wdata;
    logic        remap_set_wr, remap_clr_wr;
    logic [3:0]  remap_wdata;
    logic [2:0]  req_id;
    logic [31:0] req_addr;
    logic [31:0] xlat_addr;
    logic        xlat_remapped;

    int checks = 0;
    int failures = 0;

    // Reference state kept independently of the design
    int mdl_lo, mdl_hi;
    bit [3:0] mdl_mask;

    boot_remap u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_lo_wr(base_lo_wr), .base_hi_wr(base_hi_wr), .base_wdata(base_wdata),
        .remap_set_wr(remap_set_wr), .remap_clr_wr(remap_clr_wr),
        .remap_wdata(remap_wdata),
        .req_id(req_id), .req_addr(req_addr),
        .xlat_addr(xlat_addr), .xlat_remapped(xlat_remapped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model register updates
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_lo <= 0; mdl_hi <= 0; mdl_mask <= 4'b0;
        end else begin
            if (base_lo_wr) mdl_lo <= int'(base_wdata);
            if (base_hi_wr) mdl_hi <= int'(base_wdata);
            begin
                bit [3:0] m;
                m = mdl_mask;
                if (remap_set_wr) m = m | remap_wdata;
                if (remap_clr_wr) m = m & ~remap_wdata;
                mdl_mask <= m;
            end
        end
    end

    task automatic compare(input string tag);
        longint unsigned exp;
        bit hit;
        hit = req_id[2] && mdl_mask[req_id[1:0]] && (req_addr < 32'h0020_0000);
        if (hit) exp = longint'(mdl_hi) * 32'h0200_0000 + longint'(mdl_lo) * 32'h0020_0000
                       + longint'(req_addr);
        else     exp = longint'(req_addr);
        checks++;
        if (xlat_addr != exp[31:0] || xlat_remapped != hit) begin
            failures++;
            $display("FAIL %s: addr=%08h remap=%0b expected addr=%08h remap=%0b",
                     tag, xlat_addr, xlat_remapped, exp[31:0], hit);
        end
    endtask

    // Apply one cycle of stimulus after a falling edge and compare
    task automatic step(input string tag, input bit lw, input bit hw, input bit [3:0] nd,
                        input bit sw, input bit cw, input bit [3:0] md,
                        input bit [2:0] id, input bit [31:0] a);
        @(negedge clk);
        base_lo_wr = lw; base_hi_wr = hw; base_wdata = nd;
        remap_set_wr = sw; remap_clr_wr = cw; remap_wdata = md;
        req_id = id; req_addr = a;
        #1 compare(tag);
    endtask

    task automatic req(input string tag, input bit [2:0] id, input bit [31:0] a);
        step(tag, 0, 0, 4'h0, 0, 0, 4'h0, id, a);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        base_lo_wr = 0; base_hi_wr = 0; base_wdata = 0;
        remap_set_wr = 0; remap_clr_wr = 0; remap_wdata = 0;
        req_id = 3'b100; req_addr = 32'h0000_1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state passes everything through
        for (int s = 0; s < 4; s++) req("R1 reset passthru", 3'(4 + s), 32'h0000_0040);

        // R2: program base, low then high nibble
        step("R2 lo write", 1, 0, 4'h5, 0, 0, 4'h0, 3'b100, 32'h0);
        step("R2 hi write", 0, 1, 4'hA, 0, 0, 4'h0, 3'b100, 32'h0);
        // R7: base set but no enables yet
        req("R7 disabled secondary", 3'b100, 32'h0000_1234);

        // R3: enable secondaries 0 and 2
        step("R3 set mask", 0, 0, 4'h0, 1, 0, 4'b0101, 3'b100, 32'h0000_1234);
        req("R4 sec0 remap", 3'b100, 32'h0000_1234);
        req("R7 sec1 bypass", 3'b101, 32'h0000_1234);
        req("R4 sec2 remap", 3'b110, 32'h0000_0000);
        req("R6 master bypass", 3'b000, 32'h0000_1234);
        req("R6 master idx2 bypass", 3'b010, 32'h0000_0100);
        req("R5 window edge in", 3'b100, 32'h001F_FFFF);
        req("R5 window edge out", 3'b100, 32'h0020_0000);
        req("R5 high address", 3'b110, 32'h8000_0010);

        // R8: two requests in one low phase, no edge between
        @(negedge clk);
        req_id = 3'b100; req_addr = 32'h0000_0abc;
        #1 compare("R8 same cycle a");
        req_id = 3'b101; req_addr = 32'h0000_0def;
        #1 compare("R8 same cycle b");

        // R9: rewrite high nibble only; low nibble must be kept
        step("R9 hi write", 0, 1, 4'h3, 0, 0, 4'h0, 3'b100, 32'h0001_0000);
        req("R9 lo retained", 3'b100, 32'h0001_0000);
        step("R9 lo write", 1, 0, 4'hF, 0, 0, 4'h0, 3'b110, 32'h0000_0008);
        req("R9 hi retained", 3'b110, 32'h0000_0008);

        // R3: set and clear together, clear wins on overlap
        step("R3 set+clr", 0, 0, 4'h0, 1, 1, 4'b0011, 3'b100, 32'h0000_0010);
        req("R3 sec0 cleared", 3'b100, 32'h0000_0010);
        req("R3 sec1 still off", 3'b101, 32'h0000_0010);
        req("R3 sec2 kept", 3'b110, 32'h0000_0010);
        step("R3 set sec3", 0, 0, 4'h0, 1, 0, 4'b1000, 3'b111, 32'h0000_0020);
        req("R3 sec3 on", 3'b111, 32'h0000_0020);
        step("R3 clr sec2", 0, 0, 4'h0, 0, 1, 4'b0100, 3'b110, 32'h0000_0020);
        req("R3 sec2 off", 3'b110, 32'h0000_0020);

        // R1: reset mid-run clears base and enables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        req("R1 after reset sec3", 3'b111, 32'h0000_0020);
        step("R1 enable after reset", 0, 0, 4'h0, 1, 0, 4'b1111, 3'b111, 32'h0000_0020);
        req("R1 base zero after reset", 3'b111, 32'h0000_0020);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule